// File: doc/BRIEF.md
# Serial EEPROM Write-Command Receiver

This block is the receive side of a two-wire serial slave, and it handles write commands to a 32 KiB byte-addressed EEPROM. It runs on a synchronous system clock. The clock and data lines pass through multi-flop synchronizers before any logic uses them. From the synchronized lines the block detects START and STOP conditions and the clock edges.

Each command starts with a control byte. The block checks it against a fixed device code, the three chip-select strap pins and the write direction. If the control byte is accepted, the block collects a two-byte word address, high byte first. It then collects any number of data bytes. It pulls the data line low on the ninth clock of each byte it accepts.

The block hands its results to a downstream page-buffer engine, which owns page wrapping and the timed write cycle. It passes:
- the assembled address, with a load strobe;
- each data byte, with a valid strobe;
- a STOP strobe, tagged with the write-protect level sampled at that moment.

While the engine reports a write cycle in progress, the block refuses its own control byte. Write protection never changes the acknowledge behaviour.

Top module: `i2c_eeprom_wr_rx`

## Requirements
- R1: START (data falling while clock is high) begins decoding of a control byte. A control byte accepted by R3 is acknowledged. Its bits, from MSB to LSB, are device code 1010, then chip-select bits matching `strap_i[2:0]`, then the direction bit 0.
- R2: The acknowledge (`sda_oe_o` = 1) is driven only during the ninth clock of an accepted byte. It is released after that clock falls. Out of reset, `sda_oe_o` and all strobes are 0.
- R3: A control byte with a wrong device code, wrong chip-select bits or direction bit 1 is not acknowledged. The block then ignores the bus (no acknowledge, no strobe) until the next START.
- R4: While `busy_i` is high, a control byte that would otherwise match is not acknowledged.
- R5: After the control byte, the block receives the high address byte and then the low address byte. `addr_o` = {high byte bits [ADDR_W-9:0], low byte}, so with ADDR_W = 15 the MSB of the high byte is ignored. `addr_load_o` pulses for one cycle after the low byte.
- R6: Each later byte is acknowledged and presented on `data_o` with a one-cycle `data_valid_o` pulse, in bus order.
- R7: STOP (data rising while clock is high) pulses `stop_o` only if at least one data byte was received since the last START. At that pulse, `stop_wp_o` holds the value `wp_i` had when the STOP was detected.
- R8: `wp_i` has no effect on acknowledges or on the address and data strobes.
- R9: A repeated START in the middle of a command discards the partial command. Decoding begins again with a new control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| strap_i | input | 3 | Chip-select strap pins |
| busy_i | input | 1 | Downstream write cycle in progress |
| wp_i | input | 1 | Write-protect level |
| addr_o | output | ADDR_W | Word address of the command |
| addr_load_o | output | 1 | One-cycle strobe: `addr_o` is new |
| data_o | output | 8 | Received data byte |
| data_valid_o | output | 1 | One-cycle strobe: `data_o` is new |
| stop_o | output | 1 | One-cycle strobe: command ended with data |
| stop_wp_o | output | 1 | `wp_i` sampled at the STOP |

## Verification
The bench uses the default parameters: ADDR_W = 15, two synchronizer stages and device code 1010. With these values the ignored top address bit is observable: sending high byte 0x92 must give address 0x1234. The strap value 101 is chosen so that a single flipped chip-select bit gives a distinct rejected control byte. The serial clock quarter-period is ten system clocks, which leaves room for the three-cycle sampling delay. That delay gives each strobe and acknowledge edge a well-defined cycle inside every serial clock phase, so repeated START, STOP without data and rejected commands can each be placed exactly.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_AHI,
      ST_ALO,
      ST_DATA
   } wr_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_wr_sync.sv
module i2c_wr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RESET_VAL;
            else if (s == 0) chain_q[s] <= d_i;
            else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_wr_events.sv
module i2c_wr_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/i2c_wr_ctrl.sv
module i2c_wr_ctrl
   import i2c_wr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 15,
   parameter logic [3:0]  DEV_CODE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   input  logic              wp_i,
   output logic              sda_oe_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_load_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              data_valid_o,
   output logic              stop_o,
   output logic              stop_wp_o
);
   localparam int unsigned HI_W = ADDR_W - BYTE_W;

   wr_state_t         state_q, next_st;
   logic [3:0]        bitcnt_q;
   logic              in_ack_q, acked_q, got_data_q, accept;
   logic [BYTE_W-1:0] shreg_q;
   logic [HI_W-1:0]   hi_q;

   always_comb begin
      accept  = 1'b0;
      next_st = ST_IDLE;
      case (state_q)
         ST_CTRL: begin
            accept  = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == strap_i)
                      && !shreg_q[0] && !busy_i;
            next_st = ST_AHI;
         end
         ST_AHI:  begin accept = 1'b1; next_st = ST_ALO;  end
         ST_ALO:  begin accept = 1'b1; next_st = ST_DATA; end
         ST_DATA: begin accept = 1'b1; next_st = ST_DATA; end
         default: begin accept = 1'b0; next_st = ST_IDLE; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         bitcnt_q     <= '0;
         in_ack_q     <= 1'b0;
         acked_q      <= 1'b0;
         got_data_q   <= 1'b0;
         shreg_q      <= '0;
         hi_q         <= '0;
         sda_oe_o     <= 1'b0;
         addr_o       <= '0;
         addr_load_o  <= 1'b0;
         data_o       <= '0;
         data_valid_o <= 1'b0;
         stop_o       <= 1'b0;
         stop_wp_o    <= 1'b0;
      end else begin
         addr_load_o  <= 1'b0;
         data_valid_o <= 1'b0;
         stop_o       <= 1'b0;
         if (start_p) begin
            state_q    <= ST_CTRL;
            bitcnt_q   <= '0;
            in_ack_q   <= 1'b0;
            got_data_q <= 1'b0;
            sda_oe_o   <= 1'b0;
         end else if (stop_p) begin
            if (state_q == ST_DATA && got_data_q) begin
               stop_o    <= 1'b1;
               stop_wp_o <= wp_i;
            end
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            in_ack_q <= 1'b0;
            sda_oe_o <= 1'b0;
         end else if (state_q != ST_IDLE) begin
            if (scl_rise && !in_ack_q && bitcnt_q < 4'd8) begin
               shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
               bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && !in_ack_q && bitcnt_q == 4'd8) begin
               in_ack_q <= 1'b1;
               acked_q  <= accept;
               sda_oe_o <= accept;
               if (accept) begin
                  case (state_q)
                     ST_AHI: hi_q <= shreg_q[HI_W-1:0];
                     ST_ALO: begin
                        addr_o      <= {hi_q, shreg_q};
                        addr_load_o <= 1'b1;
                     end
                     ST_DATA: begin
                        data_o       <= shreg_q;
                        data_valid_o <= 1'b1;
                        got_data_q   <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end else if (scl_fall && in_ack_q) begin
               in_ack_q <= 1'b0;
               sda_oe_o <= 1'b0;
               bitcnt_q <= '0;
               state_q  <= acked_q ? next_st : ST_IDLE;
            end
         end
      end
   end
endmodule

// File: rtl/i2c_eeprom_wr_rx.sv
module i2c_eeprom_wr_rx #(
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   input  logic              wp_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_load_o,
   output logic [7:0]        data_o,
   output logic              data_valid_o,
   output logic              stop_o,
   output logic              stop_wp_o
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 9..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;

   i2c_wr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2c_wr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2c_wr_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall));

   i2c_wr_ctrl #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .strap_i(strap_i), .busy_i(busy_i), .wp_i(wp_i),
      .sda_oe_o(sda_oe_o), .addr_o(addr_o), .addr_load_o(addr_load_o),
      .data_o(data_o), .data_valid_o(data_valid_o),
      .stop_o(stop_o), .stop_wp_o(stop_wp_o));
endmodule

// File: rtl/i2c_eeprom_wr_rx_chk.sv
module i2c_eeprom_wr_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_oe_o,
   input logic wp_i,
   input logic addr_load_o,
   input logic data_valid_o,
   input logic stop_o,
   input logic stop_wp_o
);
   p_addr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load_o |=> !addr_load_o);
   p_data_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |=> !data_valid_o);
   p_addr_not_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> !addr_load_o);
   p_stop_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !stop_o);
   p_stop_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> (stop_wp_o == $past(wp_i)));
   p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> !sda_oe_o);
endmodule

bind i2c_eeprom_wr_rx i2c_eeprom_wr_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .wp_i(wp_i),
   .addr_load_o(addr_load_o), .data_valid_o(data_valid_o),
   .stop_o(stop_o), .stop_wp_o(stop_wp_o));

// File: tb/i2c_eeprom_wr_rx_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_wr_rx_bench;
   localparam int Q = 10;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] CTRL_W = {4'b1010, STRAP, 1'b0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic busy = 1'b0, wp = 1'b0;
   logic sda_oe, addr_load, data_valid, stop_s, stop_wp;
   logic [14:0] addr;
   logic [7:0] data;
   logic sda_line;

   int checks = 0, errors = 0;
   int n_addr = 0, n_data = 0, n_stop = 0;
   logic [14:0] last_addr;
   logic last_wp;
   logic [7:0] dbuf [0:7];
   bit done = 0;

   always #5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_eeprom_wr_rx u_i2c_eeprom_wr_rx (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .strap_i(STRAP), .busy_i(busy), .wp_i(wp),
      .addr_o(addr), .addr_load_o(addr_load), .data_o(data), .data_valid_o(data_valid),
      .stop_o(stop_s), .stop_wp_o(stop_wp));

   always @(negedge clk) begin
      if (addr_load) begin n_addr++; last_addr = addr; end
      if (data_valid) begin
         if (n_data < 8) dbuf[n_data] = data;
         n_data++;
      end
      if (stop_s) begin n_stop++; last_wp = stop_wp; end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_mon();
      n_addr = 0; n_data = 0; n_stop = 0;
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(2*Q);
      sda_m = 1'b0; hold(2*Q);
      scl_m = 1'b0; hold(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b1; hold(2*Q);
      sda_m = 1'b1; hold(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hold(Q);
         scl_m = 1'b1; hold(2*Q);
         scl_m = 1'b0; hold(Q);
      end
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(Q);
      ack = !sda_line;
      hold(Q);
      scl_m = 1'b0; hold(Q);
      check(sda_oe == 1'b0, "R2 release after ninth clock", sda_oe, 0);
   endtask

   task automatic t_reset();
      check(sda_oe == 0, "R2 reset sda_oe", sda_oe, 0);
      check(addr_load == 0 && data_valid == 0 && stop_s == 0, "R2 reset strobes",
            {addr_load, data_valid, stop_s}, 0);
   endtask

   task automatic t_byte_write();
      bit a;
      clr_mon();
      i2c_start();
      send_byte(CTRL_W, a); check(a, "R1 control ack", a, 1);
      send_byte(8'h92, a);  check(a, "R5 high addr ack", a, 1);
      send_byte(8'h34, a);  check(a, "R5 low addr ack", a, 1);
      send_byte(8'hA5, a);  check(a, "R6 data ack", a, 1);
      i2c_stop(); hold(5);
      check(n_addr == 1 && last_addr == 15'h1234, "R5 address MSB ignored", last_addr, 15'h1234);
      check(n_data == 1 && dbuf[0] == 8'hA5, "R6 byte write data", dbuf[0], 8'hA5);
      check(n_stop == 1 && last_wp == 0, "R7 stop strobe", n_stop, 1);
   endtask

   task automatic t_page_write();
      bit a;
      bit all_ack = 1;
      clr_mon();
      i2c_start();
      send_byte(CTRL_W, a); all_ack &= a;
      send_byte(8'h7F, a);  all_ack &= a;
      send_byte(8'hC0, a);  all_ack &= a;
      send_byte(8'h11, a);  all_ack &= a;
      send_byte(8'h22, a);  all_ack &= a;
      send_byte(8'h33, a);  all_ack &= a;
      i2c_stop(); hold(5);
      check(all_ack, "R6 page acks", all_ack, 1);
      check(last_addr == 15'h7FC0, "R5 page address", last_addr, 15'h7FC0);
      check(n_data == 3, "R6 data count", n_data, 3);
      check(dbuf[0] == 8'h11 && dbuf[1] == 8'h22 && dbuf[2] == 8'h33, "R6 data order",
            {dbuf[0], dbuf[1], dbuf[2]}, 24'h112233);
      check(n_stop == 1, "R7 page stop", n_stop, 1);
   endtask

   task automatic t_reject(input logic [7:0] ctrl, input string req);
      bit a, b;
      clr_mon();
      i2c_start();
      send_byte(ctrl, a);
      send_byte(8'h00, b);
      send_byte(8'h12, b);
      send_byte(8'h55, b);
      i2c_stop(); hold(5);
      check(!a, req, a, 0);
      check(!b && n_addr == 0 && n_data == 0 && n_stop == 0, "R3 bus ignored after reject",
            {b, 8'(n_addr), 8'(n_data), 8'(n_stop)}, 0);
   endtask

   task automatic t_busy();
      bit a;
      clr_mon();
      busy = 1'b1;
      i2c_start();
      send_byte(CTRL_W, a);
      i2c_stop(); hold(5);
      busy = 1'b0;
      check(!a, "R4 no ack while busy", a, 0);
   endtask

   task automatic t_wp();
      bit a;
      bit all_ack = 1;
      clr_mon();
      wp = 1'b1;
      i2c_start();
      send_byte(CTRL_W, a); all_ack &= a;
      send_byte(8'h00, a);  all_ack &= a;
      send_byte(8'h10, a);  all_ack &= a;
      send_byte(8'h5A, a);  all_ack &= a;
      i2c_stop(); hold(5);
      wp = 1'b0;
      check(all_ack, "R8 acks with wp high", all_ack, 1);
      check(n_addr == 1 && n_data == 1, "R8 strobes with wp high", n_addr + n_data, 2);
      check(n_stop == 1 && last_wp == 1, "R7 stop_wp reports wp", last_wp, 1);
   endtask

   task automatic t_restart();
      bit a;
      clr_mon();
      i2c_start();
      send_byte(CTRL_W, a);
      send_byte(8'h01, a);
      i2c_start();
      send_byte(CTRL_W, a); check(a, "R9 control after repeated start", a, 1);
      send_byte(8'h05, a);
      send_byte(8'h06, a);
      send_byte(8'h77, a);
      i2c_stop(); hold(5);
      check(n_addr == 1 && last_addr == 15'h0506, "R9 address from new command", last_addr, 15'h0506);
      check(n_data == 1 && dbuf[0] == 8'h77, "R9 data after restart", dbuf[0], 8'h77);
   endtask

   task automatic t_no_data();
      bit a;
      clr_mon();
      i2c_start();
      send_byte(CTRL_W, a);
      send_byte(8'h02, a);
      send_byte(8'h03, a);
      i2c_stop(); hold(5);
      check(n_addr == 1, "R7 address loaded", n_addr, 1);
      check(n_stop == 0, "R7 no stop strobe without data", n_stop, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      hold(4);
      t_reset();
      rst_n = 1'b1;
      hold(10);
      t_byte_write();
      t_page_write();
      t_reject(8'hBA, "R3 wrong device code");
      t_reject({4'b1010, 3'b100, 1'b0}, "R3 wrong strap");
      t_reject({4'b1010, STRAP, 1'b1}, "R3 read direction");
      t_busy();
      t_wp();
      t_restart();
      t_no_data();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule